// File: doc/BRIEF.md
# Board-Level NAND Chain Connectivity Tester

This block provides a board-test mode in which a set of digital input pads is folded through a serial chain of two-input NAND stages. The result is presented on a single output pad, so that test equipment can confirm that every pad is connected and that no two pads are shorted together. It does this by driving simple walking patterns on the inputs and watching the one output change. The chain is ordered. Index 0 is the far end, which holds the interrupt pad. Index `NUM_PINS-1` is the stage closest to the output and holds the thermal/general-purpose pad. The stages between them cover the fan tachometer, general-purpose and two-wire serial clock and data pads.

Test mode is chosen once per power cycle. A strap input is sampled on the first clock after the power-on reset is released, and the result is latched. While the mode is latched, the chain result drives the shared thermal/general-purpose output pad. In normal mode the output enable stays low and the test output is held at 0, so the pad is left to its normal function.

Top module: `nand_tree_test`

## Requirements
- R1: On the first rising clock edge at which `por_i` is low after having been high, `test_mode_o` takes the value of `strap_i`. It is visible after that edge.
- R2: `strap_i` has no effect while `por_i` is high or after that first sample. The latched mode holds until `por_i` is raised again.
- R3: In test mode, let j be the highest index with `pins_i[j]==0`, or j = -1 if every input is high. `tree_out_o` is 1 when `NUM_PINS-1-j` is even and 0 when it is odd.
- R4: In test mode, start with all inputs low, where the output is 1. Raise inputs one per step, from index `NUM_PINS-1` down to index 0. The output inverts on every step.
- R5: In test mode, start with all inputs high, where the output is 1 for even `NUM_PINS` and 0 for odd. Lower inputs one per step, from index 0 up to index `NUM_PINS-1`. The output inverts on every step.
- R6: When the latched mode is normal, `tree_oe_o` is 0 and `tree_out_o` is 0 for any input pattern.
- R7: While `por_i` is high, `test_mode_o` and `tree_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| strap_i | input | 1 | Mode strap; high selects test mode |
| pins_i | input | NUM_PINS | Chain inputs; index 0 farthest from output, top index nearest |
| tree_out_o | output | 1 | Chain result toward the output pad (0 in normal mode) |
| tree_oe_o | output | 1 | Output-pad enable; high only in test mode |
| test_mode_o | output | 1 | Latched mode, 1 = test |

## Verification
On every cycle, the assertions check the following. The mode is captured from the strap on the first clock after reset and then stays put. The pad enable follows the mode. The pad carries 0 whenever it is not enabled. A low nearest input forces the chain result to 1. Only the bench scenarios can show the parity result across whole patterns and the toggle-per-step property of both walking sequences. They also show that the strap is ignored before and after its sampling edge, and that a fresh reset can re-enter normal mode.

// File: rtl/nt_pkg.sv
package nt_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_TEST   = 1'b1
    } nt_mode_e;

    typedef struct packed {
        logic     sampled;
        nt_mode_e mode;
    } nt_strap_t;

    typedef struct packed {
        logic oe;
        logic data;
    } nt_pad_t;

    localparam int NT_DEF_PINS = 18;

    function automatic logic nt_nand2(input logic a, input logic b);
        return ~(a & b);
    endfunction

endpackage

// File: rtl/nt_strap_latch.sv
module nt_strap_latch
    import nt_pkg::*;
(
    input  logic      clk_i,
    input  logic      por_i,
    input  logic      strap_i,
    output nt_mode_e  mode_o
);

    nt_strap_t st_q;
    nt_strap_t st_d;

    always_comb begin
        st_d = st_q;
        if (!st_q.sampled) begin
            st_d.sampled = 1'b1;
            st_d.mode    = strap_i ? MODE_TEST : MODE_NORMAL;
        end
    end

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            st_q.sampled <= 1'b0;
            st_q.mode    <= MODE_NORMAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

    // R1: first edge after reset captures the strap
    p_capture_r1: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(st_q.sampled) |-> (st_q.mode == ($past(strap_i) ? MODE_TEST : MODE_NORMAL)));

    // R2: once captured the mode never moves until reset
    p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (por_i)
        (st_q.sampled && $past(st_q.sampled)) |-> $stable(st_q.mode));

endmodule

// File: rtl/nt_chain.sv
module nt_chain
    import nt_pkg::*;
#(
    parameter int NUM_PINS = NT_DEF_PINS
) (
    input  logic [NUM_PINS-1:0] pins_i,
    output logic                tree_o
);

    logic [NUM_PINS-1:0] stage;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign stage[i] = nt_nand2(pins_i[i], 1'b1);
        end else begin : g_link
            assign stage[i] = nt_nand2(pins_i[i], stage[i-1]);
        end
    end

    assign tree_o = stage[NUM_PINS-1];

endmodule

// File: rtl/nt_pad_drive.sv
module nt_pad_drive
    import nt_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic     clk_i,
    input  logic     por_i,
    input  nt_mode_e mode_i,
    input  logic     tree_i,
    output nt_pad_t  pad_o
);

    nt_pad_t pad_d;

    always_comb begin
        pad_d.oe   = (mode_i == MODE_TEST);
        pad_d.data = (mode_i == MODE_TEST) ? tree_i : 1'b0;
    end

    if (REG_OUT) begin : g_reg
        nt_pad_t pad_q;
        always_ff @(posedge clk_i) begin
            if (por_i) begin
                pad_q <= '0;
            end else begin
                pad_q <= pad_d;
            end
        end
        assign pad_o = pad_q;
    end else begin : g_comb
        assign pad_o = pad_d;
    end

    // R6: a pad that is not enabled carries no test data
    p_idle_low_r6: assert property (@(posedge clk_i) disable iff (por_i)
        !pad_o.oe |-> !pad_o.data);

endmodule

// File: rtl/nand_tree_test.sv
module nand_tree_test
    import nt_pkg::*;
#(
    parameter int NUM_PINS = NT_DEF_PINS,
    parameter bit REG_OUT  = 1'b0
) (
    input  logic                clk_i,
    input  logic                por_i,
    input  logic                strap_i,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic                tree_out_o,
    output logic                tree_oe_o,
    output logic                test_mode_o
);

    localparam int NEAR_IDX = NUM_PINS - 1;

    nt_mode_e mode_w;
    logic     tree_w;
    nt_pad_t  pad_w;

    nt_strap_latch u_strap (
        .clk_i   (clk_i),
        .por_i   (por_i),
        .strap_i (strap_i),
        .mode_o  (mode_w)
    );

    nt_chain #(.NUM_PINS(NUM_PINS)) u_chain (
        .pins_i (pins_i),
        .tree_o (tree_w)
    );

    nt_pad_drive #(.REG_OUT(REG_OUT)) u_pad (
        .clk_i  (clk_i),
        .por_i  (por_i),
        .mode_i (mode_w),
        .tree_i (tree_w),
        .pad_o  (pad_w)
    );

    assign tree_out_o  = pad_w.data;
    assign tree_oe_o   = pad_w.oe;
    assign test_mode_o = (mode_w == MODE_TEST);

    // R3: a low input at the nearest stage forces the chain result high
    p_near_low_r3: assert property (@(posedge clk_i) disable iff (por_i)
        !pins_i[NEAR_IDX] |-> tree_w);

    // R7: nothing is enabled in the cycle after a reset edge
    p_reset_quiet_r7: assert property (@(posedge clk_i)
        $past(por_i) |-> (!test_mode_o && !tree_oe_o));

endmodule

// File: tb/nand_tree_test_test.sv
module nand_tree_test_test;

    localparam int PERIOD = 10;
    localparam int N      = 18;

    logic         clk = 1'b0;
    logic         por = 1'b1;
    logic         strap = 1'b0;
    logic [N-1:0] pins = '0;
    logic         tree_out, tree_oe, test_mode;

    int vectors = 0;
    int fails   = 0;

    always #(PERIOD/2) clk = ~clk;

    nand_tree_test #(.NUM_PINS(N), .REG_OUT(1'b0)) uut (
        .clk_i       (clk),
        .por_i       (por),
        .strap_i     (strap),
        .pins_i      (pins),
        .tree_out_o  (tree_out),
        .tree_oe_o   (tree_oe),
        .test_mode_o (test_mode)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // expected chain value from the parity rule
    function automatic logic expect_tree(input logic [N-1:0] p);
        int j = -1;
        for (int k = 0; k < N; k++) if (!p[k]) j = k;
        return ((N - 1 - j) % 2) == 0;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic power_up(input logic s);
        @(negedge clk);
        por = 1'b1;
        strap = ~s;
        step();
        strap = s;
        step();
        por = 1'b0;
        step();
    endtask

    task automatic t_reset();
        @(negedge clk);
        por = 1'b1;
        strap = 1'b1;
        pins = '0;
        step();
        step();
        chk("R7 mode in reset", test_mode, 1'b0);
        chk("R7 oe in reset", tree_oe, 1'b0);
    endtask

    task automatic t_enter();
        power_up(1'b1);
        chk("R1 strap high latched", test_mode, 1'b1);
        chk("R1 oe follows mode", tree_oe, 1'b1);
    endtask

    task automatic t_strap_ignored();
        strap = 1'b0;
        step();
        step();
        chk("R2 strap low after sample", test_mode, 1'b1);
        strap = 1'b1;
        step();
        chk("R2 strap high after sample", test_mode, 1'b1);
    endtask

    task automatic t_walk_up();
        logic prev;
        pins = '0;
        step();
        chk("R4 all low start", tree_out, 1'b1);
        prev = tree_out;
        for (int i = N - 1; i >= 0; i--) begin
            pins[i] = 1'b1;
            step();
            chk($sformatf("R4 raise %0d", i), tree_out, ~prev);
            prev = tree_out;
        end
    endtask

    task automatic t_walk_down();
        logic prev;
        pins = '1;
        step();
        chk("R5 all high start", tree_out, (N % 2) == 0);
        prev = tree_out;
        for (int i = 0; i < N; i++) begin
            pins[i] = 1'b0;
            step();
            chk($sformatf("R5 lower %0d", i), tree_out, ~prev);
            prev = tree_out;
        end
    endtask

    task automatic t_patterns();
        logic [N-1:0] pat [6];
        pat[0] = N'(18'h2AAAA);
        pat[1] = N'(18'h15555);
        pat[2] = '1 >> 1;
        pat[3] = N'(18'h0F0F0);
        pat[4] = N'(18'h3FFFE);
        pat[5] = N'(18'h1FFFF);
        for (int k = 0; k < 6; k++) begin
            pins = pat[k];
            step();
            chk($sformatf("R3 pattern %0d", k), tree_out, expect_tree(pat[k]));
        end
    endtask

    task automatic t_normal();
        power_up(1'b0);
        chk("R1 strap low latched", test_mode, 1'b0);
        pins = '1;
        step();
        chk("R6 oe low", tree_oe, 1'b0);
        chk("R6 out low all high", tree_out, 1'b0);
        pins = '0;
        step();
        chk("R6 out low all low", tree_out, 1'b0);
        strap = 1'b1;
        step();
        chk("R2 normal holds", test_mode, 1'b0);
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_enter();
        t_strap_ignored();
        t_walk_up();
        t_walk_down();
        t_patterns();
        t_normal();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule